// File: doc/BRIEF.md
# Secured configuration access controller

This block guards every path into a configuration store made of three parts: a pattern memory, a 64-bit user signature area and a single one-time security bit. A command port with a valid/ready handshake carries four operations. Pattern verify reads a pattern word back. Register preload forces one state register of an attached logic core to a chosen high or low level. Signature read and signature write reach the user signature area. A separate programming port writes pattern words. Two request inputs program the security bit and start a full erase.

Programming the security bit refuses pattern verify and register preload from the cycle in which the bit is requested. A refused command answers with an error flag and all-zero data, so pattern contents never leave the block. The signature area is exempt from the lock. The lock stays set until a full erase. The erase walks the pattern memory one word per cycle and clears the lock once the walk is done. It leaves the signature untouched. Reset stands for power-up of a blank store: pattern words, signature and lock all start at zero.

Top module: `cfg_guard`

## Requirements
- R1: After reset, rsp_valid, rsp_err, rsp_data, pl_en and pl_val are all zero, cmd_ready is 1 and the store is unlocked.
- R2: A command accepted at a clock edge (cmd_valid and cmd_ready both high) is answered with rsp_valid high right after that edge, for exactly one cycle. rsp_valid is low after any edge where no command is accepted.
- R3: Opcode 2'b00 (verify) on an unlocked store returns, in rsp_data with rsp_err low, the pattern word last written at cmd_addr through the programming port (prog_we, prog_addr, prog_data). A word that has never been written returns zero.
- R4: Opcode 2'b01 (preload) with register index cmd_addr below NREG raises pl_en bit cmd_addr, and only that bit, in the same cycle as its response. pl_val carries cmd_wdata[0] at that bit position and zeros elsewhere. The response has rsp_err low and zero data.
- R5: Opcode 2'b11 writes cmd_wdata to signature word cmd_addr (8 words of 8 bits, 64 bits in all). Opcode 2'b10 reads that word back. Both work whether or not the store is locked, and the write answers with zero data.
- R6: While the store is locked, verify and preload are refused: rsp_err is 1, rsp_data is 0 and pl_en stays 0.
- R7: A pulse on lock_req takes effect in the same cycle: a verify or preload accepted at the same edge as lock_req is already refused.
- R8: The lock is sticky. Neither later commands, nor pattern programming, nor idle time clear it. Only a full erase does.
- R9: erase_req, taken while cmd_ready is high, drops cmd_ready for exactly PAT_DEPTH cycles. Afterwards every pattern word reads zero, the lock is clear and the signature is unchanged. Pattern programming writes during the erase are dropped.
- R10: An address out of range is refused with rsp_err 1, zero data and no preload pulse. Out of range means 16 or more for verify, 8 or more for signature access, and NREG or more for preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be accepted (low during erase) |
| cmd_op | input | 2 | 00 verify, 01 preload, 10 signature read, 11 signature write |
| cmd_addr | input | ADDR_W (6) | Pattern word, signature word or register index |
| cmd_wdata | input | PAT_W (8) | Signature write data; bit 0 is the preload level |
| lock_req | input | 1 | Program the security bit |
| erase_req | input | 1 | Start a full erase |
| prog_we | input | 1 | Pattern word write strobe |
| prog_addr | input | PA_W (4) | Pattern word index |
| prog_data | input | PAT_W (8) | Pattern word value |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_err | output | 1 | Command refused |
| rsp_data | output | PAT_W (8) | Read data, zero if refused |
| pl_en | output | NREG (10) | One-hot preload strobe per core register |
| pl_val | output | NREG (10) | Level to force on the strobed register |

## Verification
On every cycle the assertions check the response timing of R2, zero data and no preload on any refused answer, a one-hot preload strobe, same-cycle refusal under lock_req, the lock holding outside an erase, cmd_ready dropping after an erase request, and refusal of out-of-range preload indices. Only the bench scenarios can show the data path itself: pattern words coming back through verify, the signature surviving lock and erase, the erase lasting exactly the pattern depth, and programming writes dropped in mid-erase. The bench compares each of these against its own model of the store.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
  typedef enum logic [1:0] {
    OP_VERIFY  = 2'b00,
    OP_PRELOAD = 2'b01,
    OP_SIG_RD  = 2'b10,
    OP_SIG_WR  = 2'b11
  } op_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_ERASE = 1'b1
  } seq_e;
endpackage

// File: rtl/cfg_guard_seq.sv
// Security bit and erase sequencer.
module cfg_guard_seq #(
  parameter int PAT_DEPTH = 16,
  localparam int PA_W = $clog2(PAT_DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            erase_req,
  input  logic            lock_req,
  output logic            busy,
  output logic            clr_en,
  output logic [PA_W-1:0] clr_addr,
  output logic            locked
);
  import cfg_guard_pkg::*;

  seq_e            st_q, st_d;
  logic [PA_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;
  logic            lock_q, lock_d;
  logic            last;

  assign last = (st_q == SEQ_ERASE) && (cnt_q == PA_W'(PAT_DEPTH - 1));

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (erase_req) begin
          st_d   = SEQ_ERASE;
          cnt_d  = '0;
          cnt_en = 1'b1;
        end
      end
      SEQ_ERASE: begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (last) st_d = SEQ_IDLE;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  // set has priority over the clear that ends an erase
  always_comb lock_d = lock_req | (lock_q & ~last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lock_q <= lock_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign busy     = (st_q == SEQ_ERASE);
  assign clr_en   = busy;
  assign clr_addr = cnt_q;
  assign locked   = lock_q;
endmodule

// File: rtl/cfg_guard_store.sv
// Pattern memory and user signature words.
module cfg_guard_store #(
  parameter int PAT_W     = 8,
  parameter int PAT_DEPTH = 16,
  parameter int SIG_WORDS = 8,
  localparam int PA_W = $clog2(PAT_DEPTH),
  localparam int SA_W = $clog2(SIG_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pat_we,
  input  logic [PA_W-1:0]  pat_waddr,
  input  logic [PAT_W-1:0] pat_wdata,
  input  logic             clr_en,
  input  logic [PA_W-1:0]  clr_addr,
  input  logic [PA_W-1:0]  pat_raddr,
  output logic [PAT_W-1:0] pat_rdata,
  input  logic             sig_we,
  input  logic [SA_W-1:0]  sig_addr,
  input  logic [PAT_W-1:0] sig_wdata,
  output logic [PAT_W-1:0] sig_rdata
);
  logic [PAT_W-1:0] pat_q [PAT_DEPTH];
  logic [PAT_W-1:0] sig_q [SIG_WORDS];

  for (genvar g = 0; g < PAT_DEPTH; g++) begin : g_pat
    logic hit_clr, hit_wr, en;
    logic [PAT_W-1:0] nxt;
    assign hit_clr = clr_en && (clr_addr == PA_W'(g));
    assign hit_wr  = pat_we && (pat_waddr == PA_W'(g));
    assign en      = hit_clr | hit_wr;
    assign nxt     = hit_clr ? '0 : pat_wdata;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pat_q[g] <= '0;
      else if (en) pat_q[g] <= nxt;
    end
  end

  for (genvar g = 0; g < SIG_WORDS; g++) begin : g_sig
    logic en;
    assign en = sig_we && (sig_addr == SA_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sig_q[g] <= '0;
      else if (en) sig_q[g] <= sig_wdata;
    end
  end

  assign pat_rdata = pat_q[pat_raddr];
  assign sig_rdata = sig_q[sig_addr];
endmodule

// File: rtl/cfg_guard_exec.sv
// Command decode, lock gating, response and preload strobes.
module cfg_guard_exec #(
  parameter int PAT_W     = 8,
  parameter int PAT_DEPTH = 16,
  parameter int SIG_WORDS = 8,
  parameter int NREG      = 10,
  parameter int ADDR_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  cfg_guard_pkg::op_e op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAT_W-1:0]  wdata,
  input  logic              lock_eff,
  input  logic [PAT_W-1:0]  pat_rd,
  input  logic [PAT_W-1:0]  sig_rd,
  output logic              sig_we,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [PAT_W-1:0]  rsp_data,
  output logic [NREG-1:0]   pl_en,
  output logic [NREG-1:0]   pl_val
);
  import cfg_guard_pkg::*;

  logic             in_pat, in_sig, in_reg;
  logic             pl_ok;
  logic             err_d;
  logic [PAT_W-1:0] data_d;
  logic [NREG-1:0]  en_d, val_d;

  assign in_pat = (addr < ADDR_W'(PAT_DEPTH));
  assign in_sig = (addr < ADDR_W'(SIG_WORDS));
  assign in_reg = (addr < ADDR_W'(NREG));

  always_comb begin
    err_d  = 1'b0;
    data_d = '0;
    pl_ok  = 1'b0;
    sig_we = 1'b0;
    unique case (op)
      OP_VERIFY: begin
        if (lock_eff || !in_pat) err_d = 1'b1;
        else                     data_d = pat_rd;
      end
      OP_PRELOAD: begin
        if (lock_eff || !in_reg) err_d = 1'b1;
        else                     pl_ok = 1'b1;
      end
      OP_SIG_RD: begin
        if (!in_sig) err_d = 1'b1;
        else         data_d = sig_rd;
      end
      OP_SIG_WR: begin
        if (!in_sig) err_d = 1'b1;
        else         sig_we = accept;
      end
      default: err_d = 1'b1;
    endcase
  end

  for (genvar g = 0; g < NREG; g++) begin : g_pl
    assign en_d[g]  = pl_ok && (addr == ADDR_W'(g));
    assign val_d[g] = en_d[g] & wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      pl_en     <= '0;
      pl_val    <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= accept & err_d;
      rsp_data  <= accept ? data_d : '0;
      pl_en     <= accept ? en_d : '0;
      pl_val    <= accept ? val_d : '0;
    end
  end
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard #(
  parameter int PAT_W     = 8,
  parameter int PAT_DEPTH = 16,
  parameter int SIG_BITS  = 64,
  parameter int NREG      = 10,
  parameter int ADDR_W    = 6,
  localparam int SIG_WORDS = SIG_BITS / PAT_W,
  localparam int PA_W      = $clog2(PAT_DEPTH),
  localparam int SA_W      = $clog2(SIG_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PAT_W-1:0]  cmd_wdata,
  input  logic              lock_req,
  input  logic              erase_req,
  input  logic              prog_we,
  input  logic [PA_W-1:0]   prog_addr,
  input  logic [PAT_W-1:0]  prog_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [PAT_W-1:0]  rsp_data,
  output logic [NREG-1:0]   pl_en,
  output logic [NREG-1:0]   pl_val
);
  import cfg_guard_pkg::*;

  logic             busy, clr_en, locked, accept, sig_we;
  logic [PA_W-1:0]  clr_addr;
  logic [PAT_W-1:0] pat_rd, sig_rd;
  op_e              op;

  assign cmd_ready = ~busy;
  assign accept    = cmd_valid & cmd_ready;
  assign op        = op_e'(cmd_op);

  cfg_guard_seq #(.PAT_DEPTH(PAT_DEPTH)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .erase_req(erase_req & ~busy), .lock_req(lock_req),
    .busy(busy), .clr_en(clr_en), .clr_addr(clr_addr), .locked(locked)
  );

  cfg_guard_store #(.PAT_W(PAT_W), .PAT_DEPTH(PAT_DEPTH), .SIG_WORDS(SIG_WORDS)) u_store (
    .clk(clk), .rst_n(rst_n),
    .pat_we(prog_we & ~busy), .pat_waddr(prog_addr), .pat_wdata(prog_data),
    .clr_en(clr_en), .clr_addr(clr_addr),
    .pat_raddr(cmd_addr[PA_W-1:0]), .pat_rdata(pat_rd),
    .sig_we(sig_we), .sig_addr(cmd_addr[SA_W-1:0]), .sig_wdata(cmd_wdata),
    .sig_rdata(sig_rd)
  );

  cfg_guard_exec #(.PAT_W(PAT_W), .PAT_DEPTH(PAT_DEPTH), .SIG_WORDS(SIG_WORDS),
                   .NREG(NREG), .ADDR_W(ADDR_W)) u_exec (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .op(op), .addr(cmd_addr), .wdata(cmd_wdata),
    .lock_eff(locked | lock_req),
    .pat_rd(pat_rd), .sig_rd(sig_rd), .sig_we(sig_we),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .pl_en(pl_en), .pl_val(pl_val)
  );
endmodule

// File: rtl/cfg_guard_chk.sv
module cfg_guard_chk #(
  parameter int PAT_W  = 8,
  parameter int NREG   = 10,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              lock_req,
  input logic              erase_req,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [PAT_W-1:0]  rsp_data,
  input logic [NREG-1:0]   pl_en,
  input logic              locked,
  input logic              busy
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  assert_refused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0 && pl_en == '0));
  assert_preload_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pl_en) && ((pl_en != '0) -> (rsp_valid && !rsp_err)));
  assert_lock_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && lock_req && !cmd_op[1]) |=> (rsp_valid && rsp_err));
  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !busy) |=> locked);
  assert_erase_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && cmd_ready) |=> !cmd_ready);
  assert_bad_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'b01 && cmd_addr >= ADDR_W'(NREG)) |=> (rsp_err && pl_en == '0));
endmodule

bind cfg_guard cfg_guard_chk #(.PAT_W(PAT_W), .NREG(NREG), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_addr(cmd_addr), .lock_req(lock_req), .erase_req(erase_req),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data), .pl_en(pl_en),
  .locked(locked), .busy(busy)
);

// File: tb/tb_cfg_guard.sv
module tb_cfg_guard;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8, DEPTH = 16, NREG = 10, AW = 6, SW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, cmd_ready, lock_req, erase_req, prog_we;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [PW-1:0] cmd_wdata, prog_data, rsp_data;
  logic [3:0] prog_addr;
  logic rsp_valid, rsp_err;
  logic [NREG-1:0] pl_en, pl_val;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  logic [PW-1:0] m_pat [DEPTH];
  logic [PW-1:0] m_sig [SW];
  bit m_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_guard dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .lock_req(lock_req), .erase_req(erase_req),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
    .pl_en(pl_en), .pl_val(pl_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(input logic [1:0] op, input int a, input bit lk);
    case (op)
      2'b00:   return lk || a >= DEPTH;
      2'b01:   return lk || a >= NREG;
      default: return a >= SW;
    endcase
  endfunction

  function automatic logic [PW-1:0] exp_data(input logic [1:0] op, input int a, input bit lk);
    if (exp_err(op, a, lk)) return '0;
    if (op == 2'b00) return m_pat[a];
    if (op == 2'b10) return m_sig[a];
    return '0;
  endfunction

  // called at a negedge; returns at the next negedge with checks done
  task automatic cmd(input logic [1:0] op, input int a, input logic [PW-1:0] wd,
                     input bit lk, input string req);
    bit le, e;
    logic [PW-1:0] d;
    logic [NREG-1:0] en, v;
    le = m_lock | lk;
    e  = exp_err(op, a, le);
    d  = exp_data(op, a, le);
    en = (op == 2'b01 && !e) ? (NREG'(1) << a) : '0;
    v  = wd[0] ? en : '0;
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(a); cmd_wdata = wd; lock_req = lk;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0; lock_req = 0;
    chk({req, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({req, " rsp_err"}, 32'(rsp_err), 32'(e));
    chk({req, " rsp_data"}, 32'(rsp_data), 32'(d));
    chk({req, " pl_en"}, 32'(pl_en), 32'(en));
    chk({req, " pl_val"}, 32'(pl_val), 32'(v));
    if (lk) m_lock = 1;
    if (op == 2'b11 && !e) m_sig[a] = wd;
  endtask

  task automatic prog(input int a, input logic [PW-1:0] d);
    prog_we = 1; prog_addr = 4'(a); prog_data = d;
    @(posedge clk); @(negedge clk);
    prog_we = 0;
    m_pat[a] = d;
  endtask

  task automatic erase();
    int low = 0;
    erase_req = 1;
    @(posedge clk); @(negedge clk);
    erase_req = 0;
    while (!cmd_ready && low < 100) begin
      low++;
      prog_we = (low == 5); prog_addr = 4'd0; prog_data = 8'hA5; // dropped, R9
      @(negedge clk);
    end
    prog_we = 0;
    chk("R9 erase busy cycles", 32'(low), 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) m_pat[i] = '0;
    m_lock = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EC0_0D1E));
    for (int i = 0; i < DEPTH; i++) m_pat[i] = '0;
    for (int i = 0; i < SW; i++) m_sig[i] = '0;
    m_lock = 0;
    cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_wdata = 0;
    lock_req = 0; erase_req = 0; prog_we = 0; prog_addr = 0; prog_data = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 rsp_err", 32'(rsp_err), 0);
    chk("R1 pl_en", 32'(pl_en), 0);
    chk("R1 cmd_ready", 32'(cmd_ready), 1);
    cmd(2'b00, 7, 0, 0, "R1 blank verify");

    // R3 verify of programmed words, R10 range
    prog(0, 8'h3C); prog(15, 8'hC3); prog(6, 8'h81);
    cmd(2'b00, 0, 0, 0, "R3 verify w0");
    cmd(2'b00, 15, 0, 0, "R3 verify w15");
    cmd(2'b00, 6, 0, 0, "R3 verify w6");
    cmd(2'b00, 16, 0, 0, "R10 verify addr16");

    // R5 signature
    for (int i = 0; i < SW; i++) cmd(2'b11, i, 8'(8'h11 * (i + 1)), 0, "R5 sig write");
    for (int i = 0; i < SW; i++) cmd(2'b10, i, 0, 0, "R5 sig read");
    cmd(2'b11, 8, 8'hFF, 0, "R10 sig write addr8");
    cmd(2'b10, 8, 0, 0, "R10 sig read addr8");

    // R4 preload, R10 index, R2 single-cycle response
    cmd(2'b01, 0, 8'h01, 0, "R4 preload r0 high");
    cmd(2'b01, 9, 8'hFE, 0, "R4 preload r9 low");
    cmd(2'b01, 9, 8'h01, 0, "R4 preload r9 high");
    cmd(2'b01, 10, 8'h01, 0, "R10 preload idx10");
    @(negedge clk);
    chk("R2 rsp_valid drops", 32'(rsp_valid), 0);
    chk("R2 pl_en drops", 32'(pl_en), 0);

    // R7 same-cycle lock, R6 refusal, R5 signature under lock
    cmd(2'b00, 0, 0, 1, "R7 verify with lock_req");
    cmd(2'b01, 3, 8'h01, 0, "R6 preload locked");
    cmd(2'b00, 15, 0, 0, "R6 verify locked");
    cmd(2'b10, 2, 0, 0, "R5 sig read locked");
    cmd(2'b11, 2, 8'h5A, 0, "R5 sig write locked");
    cmd(2'b10, 2, 0, 0, "R5 sig readback locked");

    // R8 sticky
    repeat (6) @(negedge clk);
    prog(1, 8'h77);
    cmd(2'b00, 1, 0, 0, "R8 still locked");

    // R9 erase
    erase();
    cmd(2'b00, 0, 0, 0, "R9 w0 cleared");
    cmd(2'b00, 15, 0, 0, "R9 w15 cleared");
    cmd(2'b00, 1, 0, 0, "R9 w1 cleared unlocked");
    cmd(2'b10, 2, 0, 0, "R9 sig kept");
    cmd(2'b01, 4, 8'h01, 0, "R9 preload after erase");

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 2) erase();
      else if (r < 17) prog(int'($urandom % DEPTH), 8'($urandom));
      else cmd(2'($urandom), int'($urandom % 20), 8'($urandom),
               ($urandom % 40) == 0, "R3 R4 R5 R6 random");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule